// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Field Splitter

This block is the fetch stage of a small 32-bit processor with a byte-addressed instruction memory. It keeps a program counter that comes out of reset at address zero. It shows that counter to an instruction memory port and receives the six bytes that start at that address. From the first byte it works out how long the instruction is: one, two, five or six bytes. It then splits the bytes into an opcode nibble, a function nibble, two register selectors and a 32-bit constant. The constant is assembled with its lowest byte first.

On each enabled clock edge the counter moves to the next sequential instruction. A call instead sends the counter to the call target, because that target is already held in the constant. Other control transfers are resolved further down the pipeline and are not handled here. A halt byte or an unknown opcode puts the block into a terminal status. From then on the counter stays at the offending instruction until the next reset.

Top module: `fetch_splitter`

## Requirements
- R1: After reset the program counter `pc_o` is 0 and `stat_o` reads 2'b00 (running).
- R2: `icode_o` is bits 7:4 of the byte at `pc_o` and `ifun_o` is bits 3:0 of that byte.
- R3: Opcodes 2, 3, 4, 5, 6, 0xA and 0xB carry a register byte at `pc_o+1`. For these, `ra_o` is its upper nibble and `rb_o` its lower nibble. For every other opcode both selectors read 0xF, meaning no register.
- R4: Opcodes 3, 4 and 5 take the constant from bytes `pc_o+2`..`pc_o+5`. Opcodes 7 and 8 take it from `pc_o+1`..`pc_o+4`. The lowest address holds the least significant byte. For all other opcodes `valc_o` is 0.
- R5: `valp_o` equals `pc_o` plus the instruction length. The length is 1 for opcodes 0, 1 and 9 and for unknown opcodes, 2 for opcodes 2, 6, 0xA and 0xB, 5 for opcodes 7 and 8, and 6 for opcodes 3, 4 and 5.
- R6: With `step_i` high and status running, a rising edge loads `valp_o` into the program counter. For opcode 8 (call) it loads `valc_o` instead.
- R7: With `step_i` low, the program counter and the status keep their values across the edge.
- R8: A halt byte (0x00) fetched while running and stepped sets `stat_o` to 2'b01. The program counter stays at the address of the halt byte. Both then stay frozen whatever `step_i` does.
- R9: An opcode from 0xC to 0xF fetched while running and stepped sets `stat_o` to 2'b10. The program counter stays at that instruction's address. Both then stay frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| step_i | input | 1 | Advance enable for the program counter |
| pc_o | output | 32 | Program counter, also the instruction memory address |
| imem_bytes_i | input | 48 | Six bytes starting at `pc_o`; the byte at `pc_o` is in bits 7:0 |
| icode_o | output | 4 | Opcode nibble |
| ifun_o | output | 4 | Function nibble |
| ra_o | output | 4 | First register selector, 0xF when absent |
| rb_o | output | 4 | Second register selector, 0xF when absent |
| valc_o | output | 32 | Constant of the instruction, 0 when absent |
| valp_o | output | 32 | Address of the next sequential instruction |
| stat_o | output | 2 | 00 running, 01 halted, 10 invalid opcode |

## Verification
The assertions check on every cycle that:
- the counter and status hold while the enable is low;
- a terminal status never releases the counter;
- a stepped sequential instruction lands exactly on the reported next address, and a stepped call lands on its constant;
- the length between counter and next address is always one of the four legal sizes.

Only the bench scenarios can show that the individual fields are cut from the right byte lanes. They also show the lowest-byte-first ordering of the constant and the actual per-opcode length table. They do this by walking a preloaded program and comparing every field with hand-computed values.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [1:0] {
    ST_RUN = 2'b00,
    ST_HLT = 2'b01,
    ST_INS = 2'b10
  } fetch_stat_e;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_NOP   = 4'h1;
  localparam logic [3:0] OP_RRMOV = 4'h2;
  localparam logic [3:0] OP_IRMOV = 4'h3;
  localparam logic [3:0] OP_RMMOV = 4'h4;
  localparam logic [3:0] OP_MRMOV = 4'h5;
  localparam logic [3:0] OP_ALU   = 4'h6;
  localparam logic [3:0] OP_JUMP  = 4'h7;
  localparam logic [3:0] OP_CALL  = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hA;
  localparam logic [3:0] OP_POP   = 4'hB;

  localparam logic [3:0] REG_NONE = 4'hF;

endpackage

// File: rtl/fetch_rst_sync.sv
module fetch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/fetch_len_decode.sv
module fetch_len_decode
  import fetch_pkg::*;
(
  input  logic [3:0] icode,
  output logic       has_reg,
  output logic       has_const,
  output logic       legal,
  output logic       is_halt,
  output logic       is_call
);

  always_comb begin
    has_reg   = 1'b0;
    has_const = 1'b0;
    legal     = 1'b1;
    unique case (icode)
      OP_HALT, OP_NOP, OP_RET: ;
      OP_RRMOV, OP_ALU, OP_PUSH, OP_POP: has_reg = 1'b1;
      OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
        has_reg   = 1'b1;
        has_const = 1'b1;
      end
      OP_JUMP, OP_CALL: has_const = 1'b1;
      default: legal = 1'b0;
    endcase
  end

  assign is_halt = (icode == OP_HALT);
  assign is_call = (icode == OP_CALL);

endmodule

// File: rtl/fetch_field_split.sv
module fetch_field_split
  import fetch_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = 8 * WORD_BYTES,
  localparam int FETCH_W   = 8 * (2 + WORD_BYTES)
) (
  input  logic [FETCH_W-1:0] bytes_i,
  input  logic               has_reg,
  input  logic               has_const,
  output logic [3:0]         icode,
  output logic [3:0]         ifun,
  output logic [3:0]         ra,
  output logic [3:0]         rb,
  output logic [WORD_W-1:0]  valc
);

  logic [WORD_W-1:0] const_short;
  logic [WORD_W-1:0] const_long;

  assign icode = bytes_i[7:4];
  assign ifun  = bytes_i[3:0];

  genvar g;
  generate
    for (g = 0; g < WORD_BYTES; g++) begin : g_lane
      assign const_short[8*g +: 8] = bytes_i[8*(1+g) +: 8];
      assign const_long[8*g +: 8]  = bytes_i[8*(2+g) +: 8];
    end
  endgenerate

  always_comb begin
    if (has_reg) begin
      ra = bytes_i[15:12];
      rb = bytes_i[11:8];
    end else begin
      ra = REG_NONE;
      rb = REG_NONE;
    end
    if (!has_const)   valc = '0;
    else if (has_reg) valc = const_long;
    else              valc = const_short;
  end

endmodule

// File: rtl/fetch_pc_ctrl.sv
module fetch_pc_ctrl
  import fetch_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              has_reg,
  input  logic              has_const,
  input  logic              legal,
  input  logic              is_halt,
  input  logic              is_call,
  input  logic [WORD_W-1:0] valc,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] valp,
  output fetch_stat_e       stat
);

  logic [WORD_W-1:0] pc_q, pc_d;
  fetch_stat_e       stat_q, stat_d;
  logic              upd_en;
  logic [WORD_W-1:0] len;

  always_comb begin
    len = WORD_W'(1);
    if (has_reg)   len = len + WORD_W'(1);
    if (has_const) len = len + WORD_W'(WORD_BYTES);
  end

  assign valp = pc_q + len;

  always_comb begin
    pc_d   = pc_q;
    stat_d = stat_q;
    upd_en = step_i && (stat_q == ST_RUN);
    if (!legal)       stat_d = ST_INS;
    else if (is_halt) stat_d = ST_HLT;
    else if (is_call) pc_d   = valc;
    else              pc_d   = valp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      stat_q <= ST_RUN;
    end else if (upd_en) begin
      pc_q   <= pc_d;
      stat_q <= stat_d;
    end
  end

  assign pc   = pc_q;
  assign stat = stat_q;

endmodule

// File: rtl/fetch_splitter.sv
module fetch_splitter
  import fetch_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_i,
  output logic [31:0] pc_o,
  input  logic [47:0] imem_bytes_i,
  output logic [3:0]  icode_o,
  output logic [3:0]  ifun_o,
  output logic [3:0]  ra_o,
  output logic [3:0]  rb_o,
  output logic [31:0] valc_o,
  output logic [31:0] valp_o,
  output logic [1:0]  stat_o
);

  localparam int WORD_BYTES = 4;

  logic        rst_sync_n;
  logic        has_reg, has_const, legal, is_halt, is_call;
  fetch_stat_e stat;

  fetch_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fetch_field_split #(.WORD_BYTES(WORD_BYTES)) u_split (
    .bytes_i   (imem_bytes_i),
    .has_reg   (has_reg),
    .has_const (has_const),
    .icode     (icode_o),
    .ifun      (ifun_o),
    .ra        (ra_o),
    .rb        (rb_o),
    .valc      (valc_o)
  );

  fetch_len_decode u_dec (
    .icode     (icode_o),
    .has_reg   (has_reg),
    .has_const (has_const),
    .legal     (legal),
    .is_halt   (is_halt),
    .is_call   (is_call)
  );

  fetch_pc_ctrl #(.WORD_BYTES(WORD_BYTES)) u_pc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step_i    (step_i),
    .has_reg   (has_reg),
    .has_const (has_const),
    .legal     (legal),
    .is_halt   (is_halt),
    .is_call   (is_call),
    .valc      (valc_o),
    .pc        (pc_o),
    .valp      (valp_o),
    .stat      (stat)
  );

  assign stat_o = stat;

endmodule

// File: rtl/fetch_splitter_chk.sv
module fetch_splitter_chk
  import fetch_pkg::*;
(
  input logic        clk,
  input logic        rst_q,
  input logic        step_i,
  input logic [31:0] pc_o,
  input logic [31:0] valp_o,
  input logic [31:0] valc_o,
  input logic [3:0]  icode_o,
  input logic [1:0]  stat_o
);

  logic running;
  logic seq_op;
  assign running = (stat_o == ST_RUN);
  assign seq_op  = (icode_o inside {4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6,
                                    4'h7, 4'h9, 4'hA, 4'hB});

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    !step_i |=> $stable(pc_o) && $stable(stat_o)); // R7

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_q)
    (step_i && running && seq_op) |=> (pc_o == $past(valp_o))); // R6

  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_q)
    (step_i && running && icode_o == OP_CALL) |=> (pc_o == $past(valc_o))); // R6

  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_q)
    (step_i && running && icode_o == OP_HALT) |=> (stat_o == ST_HLT) && $stable(pc_o)); // R8

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_q)
    (stat_o == ST_HLT) |=> (stat_o == ST_HLT) && $stable(pc_o)); // R8

  AST_INS_STICKY: assert property (@(posedge clk) disable iff (!rst_q)
    (stat_o == ST_INS) |=> (stat_o == ST_INS) && $stable(pc_o)); // R9

  AST_LEGAL_LENGTH: assert property (@(posedge clk) disable iff (!rst_q)
    running |-> ((valp_o - pc_o) inside {32'd1, 32'd2, 32'd5, 32'd6})); // R5

endmodule

bind fetch_splitter fetch_splitter_chk u_chk (
  .clk     (clk),
  .rst_q   (rst_sync_n),
  .step_i  (step_i),
  .pc_o    (pc_o),
  .valp_o  (valp_o),
  .valc_o  (valc_o),
  .icode_o (icode_o),
  .stat_o  (stat_o)
);

// File: tb/tb_fetch_splitter.sv
module tb_fetch_splitter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i;
  logic [31:0] pc_o;
  logic [47:0] imem_bytes_i;
  logic [3:0]  icode_o, ifun_o, ra_o, rb_o;
  logic [31:0] valc_o, valp_o;
  logic [1:0]  stat_o;

  logic [7:0] mem [256];
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  fetch_splitter dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_i       (step_i),
    .pc_o         (pc_o),
    .imem_bytes_i (imem_bytes_i),
    .icode_o      (icode_o),
    .ifun_o       (ifun_o),
    .ra_o         (ra_o),
    .rb_o         (rb_o),
    .valc_o       (valc_o),
    .valp_o       (valp_o),
    .stat_o       (stat_o)
  );

  always_comb begin
    for (int i = 0; i < 6; i++)
      imem_bytes_i[8*i +: 8] = mem[8'(pc_o[7:0] + 8'(i))];
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    step_i = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  // check fields of instruction at current pc, then take one step
  task automatic fetch_step(input logic [31:0] e_pc, input logic [3:0] e_ic,
                            input logic [3:0] e_fn, input logic [3:0] e_ra,
                            input logic [3:0] e_rb, input logic [31:0] e_c,
                            input logic [31:0] e_p);
    chk("R6", "pc", pc_o, e_pc);
    chk("R2", "icode", 32'(icode_o), 32'(e_ic));
    chk("R2", "ifun", 32'(ifun_o), 32'(e_fn));
    chk("R3", "ra", 32'(ra_o), 32'(e_ra));
    chk("R3", "rb", 32'(rb_o), 32'(e_rb));
    chk("R4", "valc", valc_o, e_c);
    chk("R5", "valp", valp_o, e_p);
    step_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_main();
    clear_mem();
    {mem[0], mem[1], mem[2], mem[3], mem[4], mem[5]} = 48'h30f4_0001_0000;
    mem[6'h06] = 8'h10;
    {mem[7], mem[8]} = 16'h6012;
    {mem[9], mem[10], mem[11], mem[12], mem[13], mem[14]} = 48'h5037_7856_3412;
    {mem[15], mem[16], mem[17], mem[18], mem[19]} = 40'h80_2000_0000;
    mem[8'h14] = 8'h00;
    {mem[8'h20], mem[8'h21]} = 16'ha04f;
    {mem[8'h22], mem[8'h23], mem[8'h24], mem[8'h25], mem[8'h26]} = 40'h73_4433_2211;
    mem[8'h27] = 8'h90;
    mem[8'h28] = 8'h00;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "reset pc", pc_o, 32'h0);
    chk("R1", "reset stat", 32'(stat_o), 32'h0);
  endtask

  task automatic t_walk();
    load_main();
    do_reset();
    fetch_step(32'h00, 4'h3, 4'h0, 4'hF, 4'h4, 32'h100, 32'h06);
    fetch_step(32'h06, 4'h1, 4'h0, 4'hF, 4'hF, 32'h0, 32'h07);
    fetch_step(32'h07, 4'h6, 4'h0, 4'h1, 4'h2, 32'h0, 32'h09);
    fetch_step(32'h09, 4'h5, 4'h0, 4'h3, 4'h7, 32'h12345678, 32'h0f);
    fetch_step(32'h0f, 4'h8, 4'h0, 4'hF, 4'hF, 32'h20, 32'h14);
  endtask

  task automatic t_hold();
    step_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", "pc held", pc_o, 32'h20);
    chk("R7", "stat held", 32'(stat_o), 32'h0);
    fetch_step(32'h20, 4'hA, 4'h0, 4'h4, 4'hF, 32'h0, 32'h22);
    fetch_step(32'h22, 4'h7, 4'h3, 4'hF, 4'hF, 32'h11223344, 32'h27);
    fetch_step(32'h27, 4'h9, 4'h0, 4'hF, 4'hF, 32'h0, 32'h28);
  endtask

  task automatic t_halt();
    chk("R8", "running before halt", 32'(stat_o), 32'h0);
    fetch_step(32'h28, 4'h0, 4'h0, 4'hF, 4'hF, 32'h0, 32'h29);
    chk("R8", "halt stat", 32'(stat_o), 32'h1);
    chk("R8", "halt pc", pc_o, 32'h28);
    repeat (3) @(negedge clk);
    chk("R8", "halt pc frozen", pc_o, 32'h28);
    chk("R8", "halt stat frozen", 32'(stat_o), 32'h1);
    step_i = 1'b0;
    do_reset();
    chk("R1", "reset after halt pc", pc_o, 32'h0);
    chk("R1", "reset after halt stat", 32'(stat_o), 32'h0);
  endtask

  task automatic t_invalid();
    clear_mem();
    mem[0] = 8'h10;
    {mem[1], mem[2]} = 16'h21ab;
    mem[3] = 8'hd5;
    do_reset();
    fetch_step(32'h00, 4'h1, 4'h0, 4'hF, 4'hF, 32'h0, 32'h01);
    fetch_step(32'h01, 4'h2, 4'h1, 4'hA, 4'hB, 32'h0, 32'h03);
    chk("R9", "bad op icode", 32'(icode_o), 32'hD);
    chk("R9", "running before bad op", 32'(stat_o), 32'h0);
    @(negedge clk);
    chk("R9", "invalid stat", 32'(stat_o), 32'h2);
    chk("R9", "invalid pc", pc_o, 32'h03);
    repeat (3) @(negedge clk);
    chk("R9", "invalid pc frozen", pc_o, 32'h03);
    chk("R9", "invalid stat frozen", 32'(stat_o), 32'h2);
    step_i = 1'b0;
  endtask

  initial begin
    clear_mem();
    t_reset();
    t_walk();
    t_hold();
    t_halt();
    t_invalid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule